// File: doc/BRIEF.md
# I2C Master Run/Abort Sequencer

This block sits between a software-visible control word and an I2C master bit engine. It holds three control bits: run-enable, abort-request and command-hold. From these bits and a few status lines reported by the engine, it derives the engine-side controls: FIFO flush requests, a one-cycle STOP request, a NACK request for an in-flight receive byte, and a qualifier that lets the engine fetch its next command.

Turning the block off is graceful. A transmit in progress is allowed to finish. A receive in progress ends at the current byte boundary with a NACK. Only then does the sequencer fall back to the off state, where both FIFOs are held flushed. An abort is requested by writing a one to the abort bit, and software cannot withdraw it. The sequencer waits for the current transfer, issues a STOP, flushes the transmit FIFO, raises a sticky abort interrupt and clears the abort bit by itself.

When the bus clock is asynchronous (parameter `ASYNC_BUS_CLK`), the enable bit passes through a two-flop synchronizer before the sequencer acts on it.

Top module: `i2cm_run_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, both flush requests are 1, and `stop_req`, `nack_req`, `cmd_fetch_ok` and `tx_abort_irq` are all 0.
- R2: The control word is laid out as bit0 = run-enable, bit1 = abort-request and bit2 = command-hold. A write to it stores bit0 and bit2 as written. Readback gives these three bits in the same positions, plus the read-only status bit3.
- R3: A write with bit1 = 1 sets the abort bit only if run-enable was already 1 before that write. Otherwise the abort bit stays 0.
- R4: Writing 0 to bit1 while an abort is pending leaves bit1 at 1.
- R5: A pending abort blocks `cmd_fetch_ok`. It waits for `eng_xfer_done`, or for `eng_idle` if the engine is idle. Then `stop_req` is 1 for exactly one cycle, and on the next cycle `txf_flush` is 1 for exactly one cycle. On the cycle after that, `tx_abort_irq` is 1 and bit1 reads 0.
- R6: While the sequencer is off (bit3 = 0), `txf_flush` and `rxf_flush` both stay at 1 and `cmd_fetch_ok` stays at 0.
- R7: When run-enable is cleared during a transmit (`eng_idle` = 0, `eng_rx_active` = 0), the sequencer stays on and the flushes stay at 0 until `eng_xfer_done`. It then issues a one-cycle `stop_req` and goes off.
- R8: When run-enable is cleared during a receive (`eng_rx_active` = 1), `nack_req` is held at 1 until `eng_byte_done`. A one-cycle `stop_req` follows, and then the sequencer goes off.
- R9: `tx_abort_irq` survives the disable. It is cleared only while the sequencer is off and `eng_idle` = 1.
- R10: With command-hold = 1, `cmd_fetch_ok` is 0 even when the transmit FIFO is not empty. With command-hold = 0, it is 1 as soon as `txf_empty` = 0.
- R11: With `ASYNC_BUS_CLK` = 1, a change of run-enable stored at clock edge k reaches the sequencer at edge k+3: two synchronizer stages plus the state register. Up to that edge, the outputs still reflect the old setting.
- R12: Bit3 reads 1 exactly while the sequencer is on. A graceful disable holds it at 1 until the shutdown completes.
- R13: A high `irq_clr` clears `tx_abort_irq`. If an abort completes in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 3 | Control-word write data |
| reg_rdata | output | 4 | Control bits plus effective-enable status in bit3 |
| irq_clr | input | 1 | Write-one-to-clear for the abort interrupt |
| tx_abort_irq | output | 1 | Sticky abort-complete interrupt flag |
| eng_idle | input | 1 | Engine reports bus idle |
| eng_byte_done | input | 1 | Engine reached a byte boundary |
| eng_xfer_done | input | 1 | Engine finished the current transfer |
| eng_rx_active | input | 1 | Engine is currently receiving |
| txf_empty | input | 1 | Transmit FIFO is empty |
| txf_flush | output | 1 | Flush request to the transmit FIFO |
| rxf_flush | output | 1 | Flush request to the receive FIFO |
| stop_req | output | 1 | One-cycle STOP request to the engine |
| nack_req | output | 1 | Do-not-acknowledge the byte in flight |
| cmd_fetch_ok | output | 1 | Engine may fetch the next command |

## Verification
The hardest case to reach is an abort that finishes in the very cycle software writes the interrupt clear. The stimulus gets there by holding `irq_clr` high for the whole of a second abort run against an idle engine, so the completion edge is bound to coincide with the clear. A second hard case is a disable that must stall at a receive byte boundary. For this, the engine model is put into receive with `eng_idle` low before the enable bit is dropped, and `eng_byte_done` is held back for several cycles. This shows that `nack_req` holds and that the status bit stays on until the STOP.

// File: rtl/i2cm_run_ctrl.sv
module i2cm_run_ctrl #(
  parameter bit ASYNC_BUS_CLK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic       irq_clr,
  output logic       tx_abort_irq,
  input  logic       eng_idle,
  input  logic       eng_byte_done,
  input  logic       eng_xfer_done,
  input  logic       eng_rx_active,
  input  logic       txf_empty,
  output logic       txf_flush,
  output logic       rxf_flush,
  output logic       stop_req,
  output logic       nack_req,
  output logic       cmd_fetch_ok
);

  typedef enum logic [2:0] {
    S_OFF, S_RUN, S_ABT_WAIT, S_ABT_STOP, S_ABT_FLUSH, S_DRN_TX, S_DRN_RX, S_DRN_STOP
  } seq_t;

  seq_t st, st_nx;
  logic en_reg, abort_reg, hold_reg, en_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_reg    <= 1'b0;
      hold_reg  <= 1'b0;
      abort_reg <= 1'b0;
    end else begin
      if (reg_wr) begin
        en_reg   <= reg_wdata[0];
        hold_reg <= reg_wdata[2];
      end
      if (st == S_ABT_FLUSH)
        abort_reg <= 1'b0;
      else if (reg_wr && reg_wdata[1] && en_reg)
        abort_reg <= 1'b1;
    end
  end

  generate
    if (ASYNC_BUS_CLK) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], en_reg};
      end
      assign en_req = sync_q[1];
    end else begin : g_direct
      assign en_req = en_reg;
    end
  endgenerate

  always_comb begin
    st_nx = st;
    case (st)
      S_OFF:       if (en_req) st_nx = S_RUN;
      S_RUN: begin
        if (abort_reg)            st_nx = S_ABT_WAIT;
        else if (!en_req) begin
          if (eng_idle)           st_nx = S_OFF;
          else if (eng_rx_active) st_nx = S_DRN_RX;
          else                    st_nx = S_DRN_TX;
        end
      end
      S_ABT_WAIT:  if (eng_idle || eng_xfer_done) st_nx = S_ABT_STOP;
      S_ABT_STOP:  st_nx = S_ABT_FLUSH;
      S_ABT_FLUSH: st_nx = S_RUN;
      S_DRN_TX:    if (eng_xfer_done || eng_idle) st_nx = S_DRN_STOP;
      S_DRN_RX:    if (eng_byte_done || eng_idle) st_nx = S_DRN_STOP;
      S_DRN_STOP:  st_nx = S_OFF;
      default:     st_nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_OFF;
      tx_abort_irq <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_ABT_FLUSH)
        tx_abort_irq <= 1'b1;
      else if (irq_clr || (st == S_OFF && eng_idle))
        tx_abort_irq <= 1'b0;
    end
  end

  assign reg_rdata    = {st != S_OFF, hold_reg, abort_reg, en_reg};
  assign txf_flush    = (st == S_OFF) || (st == S_ABT_FLUSH);
  assign rxf_flush    = (st == S_OFF);
  assign stop_req     = (st == S_ABT_STOP) || (st == S_DRN_STOP);
  assign nack_req     = (st == S_DRN_RX);
  assign cmd_fetch_ok = (st == S_RUN) && en_req && !abort_reg && !hold_reg && !txf_empty;

  p_abort_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[1]) |-> $past(reg_rdata[0]));

  p_abort_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !txf_flush) |=> reg_rdata[1]);

  p_stop_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  p_irq_after_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_flush && !rxf_flush) |=> (tx_abort_irq && !reg_rdata[1]));

  p_graceful_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[3]) |-> ($past(stop_req) || $past(eng_idle)));

  p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2] |-> !cmd_fetch_ok);

  p_nack_no_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_req |-> (!rxf_flush && !stop_req));

endmodule

// File: tb/i2cm_run_ctrl_bench.sv
module i2cm_run_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_wdata = 3'd0;
  logic [3:0] reg_rdata;
  logic irq_clr = 1'b0;
  logic tx_abort_irq;
  logic eng_idle = 1'b1, eng_byte_done = 1'b0, eng_xfer_done = 1'b0, eng_rx_active = 1'b0;
  logic txf_empty = 1'b1;
  logic txf_flush, rxf_flush, stop_req, nack_req, cmd_fetch_ok;

  always #4 clk = ~clk;

  i2cm_run_ctrl u_i2cm_run_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_clr(irq_clr), .tx_abort_irq(tx_abort_irq), .eng_idle(eng_idle),
    .eng_byte_done(eng_byte_done), .eng_xfer_done(eng_xfer_done), .eng_rx_active(eng_rx_active),
    .txf_empty(txf_empty), .txf_flush(txf_flush), .rxf_flush(rxf_flush), .stop_req(stop_req),
    .nack_req(nack_req), .cmd_fetch_ok(cmd_fetch_ok)
  );

  typedef struct {
    string      req;
    logic [9:0] exp;
    logic [9:0] msk;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // vector: {rdata[3:0], txf_flush, rxf_flush, stop_req, nack_req, cmd_fetch_ok, tx_abort_irq}
  function automatic logic [9:0] obs();
    return {reg_rdata, txf_flush, rxf_flush, stop_req, nack_req, cmd_fetch_ok, tx_abort_irq};
  endfunction

  task automatic expect_v(input string req, input logic [9:0] e, input logic [9:0] m);
    item_t it;
    it.req = req; it.exp = e; it.msk = m;
    sb_q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  localparam logic [9:0] ALL  = 10'h3FF;
  localparam logic [9:0] RD   = 10'h3C0;
  localparam logic [9:0] FL   = 10'h030;
  localparam logic [9:0] STP  = 10'h008;
  localparam logic [9:0] NCK  = 10'h004;
  localparam logic [9:0] FET  = 10'h002;
  localparam logic [9:0] IRQ  = 10'h001;

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [9:0] a;
        it = sb_q.pop_front();
        a = obs();
        checks++;
        if ((a & it.msk) !== (it.exp & it.msk)) begin
          errors++;
          $display("FAIL %s: actual %b expected %b (mask %b)", it.req, a & it.msk, it.exp & it.msk, it.msk);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    expect_v("R1", 10'b0000_11_0000, ALL);
    step();

    wr(3'b010);
    expect_v("R3", 10'b0000_11_0000, RD | FL);

    wr(3'b001);
    expect_v("R11 edge k", 10'b0001_11_0000, RD | FL);
    step(); expect_v("R11 edge k+1", 10'b0001_11_0000, RD | FL);
    step(); expect_v("R11 edge k+2", 10'b0001_11_0000, RD | FL);
    step(); expect_v("R11 R12 edge k+3", 10'b1001_00_0000, RD | FL);

    txf_empty = 1'b0;
    expect_v("R10 fetch open", 10'b0000_00_0010, FET);
    wr(3'b101);
    expect_v("R10 R2 hold", 10'b1101_00_0000, RD | FET);
    wr(3'b001);
    expect_v("R10 release", 10'b1001_00_0010, RD | FET);
    txf_empty = 1'b1;

    eng_idle = 1'b0;
    txf_empty = 1'b0;
    wr(3'b011);
    expect_v("R5 pending blocks fetch", 10'b1011_00_0000, RD | FET);
    wr(3'b001);
    expect_v("R4 no sw clear", 10'b1011_00_0000, RD | STP);
    step(); expect_v("R5 waits transfer", 10'b1011_00_0000, RD | FL | STP);
    step(); expect_v("R5 waits transfer", 10'b1011_00_0000, RD | FL | STP);
    eng_xfer_done = 1'b1;
    step();
    eng_xfer_done = 1'b0;
    txf_empty = 1'b1;
    expect_v("R5 stop", 10'b1011_00_1000, RD | FL | STP | IRQ);
    step(); expect_v("R5 flush tx", 10'b1011_10_0000, RD | FL | STP | IRQ);
    step(); expect_v("R5 irq and auto clear", 10'b1001_00_0001, RD | FL | STP | IRQ);

    irq_clr = 1'b1;
    step(); irq_clr = 1'b0;
    expect_v("R13 clear", 10'b0000_00_0000, IRQ);

    eng_idle = 1'b1;
    irq_clr = 1'b1;
    wr(3'b011);
    step(); step();
    expect_v("R5 idle abort stop", 10'b0000_00_1000, STP | IRQ);
    step();
    expect_v("R13 pre-collision", 10'b0000_10_0000, FL | IRQ);
    step();
    expect_v("R13 set wins", 10'b1001_00_0001, RD | IRQ);
    irq_clr = 1'b0;

    eng_idle = 1'b0;
    eng_rx_active = 1'b0;
    wr(3'b000);
    repeat (5) step();
    expect_v("R7 R12 draining tx", 10'b1000_00_0001, ALL);
    eng_xfer_done = 1'b1;
    step();
    eng_xfer_done = 1'b0;
    expect_v("R7 stop after transfer", 10'b1000_00_1001, ALL);
    step();
    expect_v("R7 R9 off, irq held", 10'b0000_11_0001, ALL);
    step();
    expect_v("R9 still held while busy", 10'b0000_00_0001, IRQ);
    eng_idle = 1'b1;
    step();
    expect_v("R9 cleared at idle", 10'b0000_00_0000, IRQ);

    wr(3'b001);
    repeat (3) step();
    expect_v("R11 back on", 10'b1001_00_0000, RD | FL);
    eng_idle = 1'b0;
    eng_rx_active = 1'b1;
    wr(3'b000);
    step(); step();
    expect_v("R11 R8 not yet", 10'b0000_00_0000, NCK);
    step();
    expect_v("R8 nack", 10'b1000_00_0100, RD | FL | STP | NCK);
    repeat (3) step();
    expect_v("R8 nack holds", 10'b1000_00_0100, RD | FL | STP | NCK);
    eng_byte_done = 1'b1;
    step();
    eng_byte_done = 1'b0;
    eng_rx_active = 1'b0;
    expect_v("R8 stop after byte", 10'b1000_00_1000, RD | FL | STP | NCK);
    step();
    expect_v("R8 R12 off", 10'b0000_11_0000, RD | FL | STP | NCK);

    txf_empty = 1'b0;
    wr(3'b010);
    step();
    expect_v("R6 R3 held flushed", 10'b0000_11_0000, ALL);
    step();
    expect_v("R6 still flushed", 10'b0000_11_0000, RD | FL | FET);

    step(); step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule